// File: doc/BRIEF.md
# Indexed Interrupt Redirection Router

This block routes external interrupt inputs to interrupt messages. Software reaches all of its state through just two bus locations: a select register that holds an index, and a data window that reads or writes whichever internal register the index names. Behind the window sit a unit identification register, a read-only version register and a redirection table with one 64-bit entry per input. Each entry is split into a low and a high 32-bit word at two consecutive indices.

An entry carries an 8-bit vector, a mask flag and an 8-bit destination. A rising edge on an unmasked input is latched as pending. Pending inputs are served one per clock cycle, lowest input number first. Each one is served by emitting a single-cycle message that carries the entry's vector and destination. Inputs masked at the moment of their edge are dropped.

Top module: `rt_router`

## Requirements
- R1: After reset the select register reads 0, the ID register reads 0, every entry's low word reads 0x0001_0000 (masked), every high word reads 0, and msg_valid is low.
- R2: A write at byte offset 0x00 loads the select register from wdata[7:0], and a read there returns it in bits 7:0. Offset 0x10 is the data window onto the selected register. Every other offset reads 0 and ignores writes.
- R3: Select value 0x00 names the ID register. Bits 31:24 are writable and read back, and all other bits read 0.
- R4: Select value 0x01 names the version register, which ignores writes. It reads 0x0017_0020: bits 23:16 hold the highest entry number (NUM_IN-1 = 23) and bits 7:0 hold the version code 0x20.
- R5: For entry n, the low word is at select 0x10+2n, with the vector in bits 7:0 and the mask in bit 16 (1 = masked). The high word is at 0x11+2n, with the destination in bits 31:24. All other bits of both words read 0.
- R6: Select values 0x02 to 0x0F and 0x40 to 0xFF read 0 through the window and ignore writes.
- R7: A 0-to-1 transition on an unmasked input produces exactly one message carrying that entry's vector and destination. If the input changes between clock edges, msg_valid is high for one cycle after the second following rising clock edge. An input held high produces no further messages.
- R8: An input whose entry is masked when its rising edge is sampled never produces a message for that edge, even if the entry is unmasked afterwards.
- R9: Inputs that rise in the same cycle are served on consecutive cycles in ascending input-number order, one message per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from bus_addr and state) |
| irq_in | input | 24 | External interrupt inputs, edge-sensitive |
| msg_valid | output | 1 | A message is presented this cycle |
| msg_vector | output | 8 | Vector of the served entry |
| msg_dest | output | 8 | Destination of the served entry |

## Verification
A corrupted select register or a wrong index decode shows up on the very next window read, as data from the wrong register or data that should have been zero. A pending bit that is stuck or lost shows up two edges after the input edge: as a missing message, a repeated message, or a message where none was expected. A fault in the priority order puts the messages for the simultaneous-edge burst out of ascending order within three cycles. A vector or destination taken from the wrong entry shows as a mismatch against the value written for that input.

// File: rtl/rt_router_pkg.sv
package rt_router_pkg;

    localparam logic [7:0] OFF_INDEX  = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;
    localparam logic [7:0] IDX_ID     = 8'h00;
    localparam logic [7:0] IDX_VER    = 8'h01;
    localparam logic [7:0] VER_CODE   = 8'h20;
    localparam int         MASK_POS   = 16;

    typedef struct packed {
        logic [7:0] dest;
        logic       masked;
        logic [7:0] vector;
    } rt_entry_t;

    localparam rt_entry_t ENTRY_RESET = '{dest: 8'h00, masked: 1'b1, vector: 8'h00};

    typedef struct packed {
        logic       valid;
        logic [7:0] vector;
        logic [7:0] dest;
    } rt_msg_t;

    function automatic logic [31:0] pack_lo(rt_entry_t e);
        logic [31:0] w;
        w = '0;
        w[7:0] = e.vector;
        w[MASK_POS] = e.masked;
        return w;
    endfunction

    function automatic logic [31:0] pack_hi(rt_entry_t e);
        logic [31:0] w;
        w = '0;
        w[31:24] = e.dest;
        return w;
    endfunction

endpackage

// File: rtl/rt_regfile.sv
module rt_regfile
    import rt_router_pkg::*;
#(
    parameter int NUM_IN   = 24,
    parameter int ADDR_W   = 8,
    parameter int IDX_BASE = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output rt_entry_t [NUM_IN-1:0] tbl_o,
    output logic [7:0]             index_o
);

    localparam logic [ADDR_W-1:0] A_INDEX  = ADDR_W'(OFF_INDEX);
    localparam logic [ADDR_W-1:0] A_WINDOW = ADDR_W'(OFF_WINDOW);
    localparam logic [7:0]        TOP_ENT  = 8'(NUM_IN - 1);

    logic [7:0] index_q;
    logic [7:0] id_q;
    logic       idx_wr;
    logic       win_wr;

    assign idx_wr  = bus_wr && (bus_addr == A_INDEX);
    assign win_wr  = bus_wr && (bus_addr == A_WINDOW);
    assign index_o = index_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q <= '0;
            id_q    <= '0;
        end else begin
            if (idx_wr)
                index_q <= bus_wdata[7:0];
            if (win_wr && index_q == IDX_ID)
                id_q <= bus_wdata[31:24];
        end
    end

    for (genvar g = 0; g < NUM_IN; g++) begin : g_ent
        localparam logic [7:0] LO_IDX = 8'(IDX_BASE + 2 * g);
        localparam logic [7:0] HI_IDX = 8'(IDX_BASE + 2 * g + 1);
        rt_entry_t ent_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= ENTRY_RESET;
            end else if (win_wr && index_q == LO_IDX) begin
                ent_q.vector <= bus_wdata[7:0];
                ent_q.masked <= bus_wdata[MASK_POS];
            end else if (win_wr && index_q == HI_IDX) begin
                ent_q.dest <= bus_wdata[31:24];
            end
        end

        assign tbl_o[g] = ent_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_INDEX) begin
            bus_rdata[7:0] = index_q;
        end else if (bus_addr == A_WINDOW) begin
            if (index_q == IDX_ID) begin
                bus_rdata[31:24] = id_q;
            end else if (index_q == IDX_VER) begin
                bus_rdata = {8'h00, TOP_ENT, 8'h00, VER_CODE};
            end else begin
                for (int i = 0; i < NUM_IN; i++) begin
                    if (index_q == 8'(IDX_BASE + 2 * i))
                        bus_rdata = pack_lo(tbl_o[i]);
                    else if (index_q == 8'(IDX_BASE + 2 * i + 1))
                        bus_rdata = pack_hi(tbl_o[i]);
                end
            end
        end
    end

endmodule

// File: rtl/rt_dispatch.sv
module rt_dispatch
    import rt_router_pkg::*;
#(
    parameter int NUM_IN = 24
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_IN-1:0]      irq_in,
    input  rt_entry_t [NUM_IN-1:0] tbl_i,
    output rt_msg_t                msg_o,
    output logic [NUM_IN-1:0]      pend_o,
    output logic [NUM_IN-1:0]      grant_o
);

    localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

    logic [NUM_IN-1:0] irq_q;
    logic [NUM_IN-1:0] pend_q;
    logic [NUM_IN-1:0] mask_v;
    logic [NUM_IN-1:0] rise;
    logic [NUM_IN-1:0] grant;
    logic [SEL_W-1:0]  sel;

    always_comb begin
        for (int i = 0; i < NUM_IN; i++)
            mask_v[i] = tbl_i[i].masked;
    end

    assign rise = irq_in & ~irq_q;

    // Lowest pending input wins: scan from the top so the last hit is the lowest.
    always_comb begin
        grant = '0;
        sel   = '0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                sel      = SEL_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        irq_q <= irq_in;
        if (rst) begin
            pend_q <= '0;
            msg_o  <= '0;
        end else begin
            pend_q       <= (pend_q & ~grant) | (rise & ~mask_v);
            msg_o.valid  <= |pend_q;
            msg_o.vector <= tbl_i[sel].vector;
            msg_o.dest   <= tbl_i[sel].dest;
        end
    end

    assign pend_o  = pend_q;
    assign grant_o = grant;

endmodule

// File: rtl/rt_router.sv
module rt_router
    import rt_router_pkg::*;
#(
    parameter int NUM_IN   = 24,
    parameter int ADDR_W   = 8,
    parameter int IDX_BASE = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_IN-1:0] irq_in,
    output logic              msg_valid,
    output logic [7:0]        msg_vector,
    output logic [7:0]        msg_dest
);

    rt_entry_t [NUM_IN-1:0] tbl_w;
    rt_msg_t                msg_w;
    logic [NUM_IN-1:0]      pend_w;
    logic [NUM_IN-1:0]      grant_w;
    logic [7:0]             index_w;

    rt_regfile #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W), .IDX_BASE(IDX_BASE)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tbl_o     (tbl_w),
        .index_o   (index_w)
    );

    rt_dispatch #(.NUM_IN(NUM_IN)) disp_i (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .tbl_i   (tbl_w),
        .msg_o   (msg_w),
        .pend_o  (pend_w),
        .grant_o (grant_w)
    );

    assign msg_valid  = msg_w.valid;
    assign msg_vector = msg_w.vector;
    assign msg_dest   = msg_w.dest;

endmodule

// File: rtl/rt_router_chk.sv
module rt_router_chk #(
    parameter int NUM_IN = 24,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              msg_valid,
    input logic [NUM_IN-1:0] pend,
    input logic [NUM_IN-1:0] grant,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [7:0]        index
);

    // R9: at most one input is served per cycle
    a_r9_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R7: no message appears unless something was pending
    a_r7_no_spurious_msg: assert property (@(posedge clk) disable iff (rst)
        !(|pend) |=> !msg_valid);

    // R7: pending work is always served on the next cycle
    a_r7_pending_served: assert property (@(posedge clk) disable iff (rst)
        (|pend) |=> msg_valid);

    // R4: the version field always reports the highest entry number
    a_r4_version_field: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(8'h10) && index == 8'h01) |-> bus_rdata[23:16] == 8'(NUM_IN - 1));

endmodule

bind rt_router rt_router_chk #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .pend      (pend_w),
    .grant     (grant_w),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .index     (index_w)
);

// File: tb/rt_router_tb.sv
module rt_router_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_IN     = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_IN-1:0] irq_in = '0;
    logic              msg_valid;
    logic [7:0]        msg_vector;
    logic [7:0]        msg_dest;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic [15:0] exp_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    rt_router dut_i (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_in     (irq_in),
        .msg_valid  (msg_valid),
        .msg_vector (msg_vector),
        .msg_dest   (msg_dest)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_write(8'h10, d);
    endtask

    task automatic win_read(input logic [7:0] idx, output logic [31:0] d);
        bus_write(8'h00, {24'h0, idx});
        bus_read(8'h10, d);
    endtask

    task automatic check_reg(input logic [7:0] idx, input logic [31:0] exp, input string req);
        logic [31:0] d;
        win_read(idx, d);
        chk(d === exp, req, d, exp);
    endtask

    // Driver: raise the given inputs for one cycle and queue the expected messages.
    task automatic pulse(input logic [NUM_IN-1:0] bits, input logic [15:0] exp_list[$]);
        @(negedge clk);
        irq_in = irq_in | bits;
        foreach (exp_list[k]) exp_q.push_back(exp_list[k]);
        @(negedge clk);
        irq_in = irq_in & ~bits;
    endtask

    // Monitor: compare each message with the head of the expectation queue.
    always @(negedge clk) begin
        if (!rst && msg_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7/R8 unexpected message", {16'h0, msg_vector, msg_dest}, 32'h0);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                chk({msg_vector, msg_dest} === e, "R7/R9 message content/order",
                    {16'h0, msg_vector, msg_dest}, {16'h0, e});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [15:0] none[$];
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk(msg_valid === 1'b0, "R1 msg_valid after reset", {31'h0, msg_valid}, 32'h0);
        bus_read(8'h00, d);
        chk(d === 32'h0, "R1 select register reset", d, 32'h0);
        bus_read(8'h10, d);
        chk(d === 32'h0, "R1 ID register reset", d, 32'h0);
        check_reg(8'h10, 32'h0001_0000, "R1 entry 0 low word reset");
        check_reg(8'h3F, 32'h0000_0000, "R1 entry 23 high word reset");
        check_reg(8'h2E, 32'h0001_0000, "R1 entry 15 low word reset");

        // R2: select register and other offsets
        bus_write(8'h00, 32'hFFFF_FF2A);
        bus_read(8'h00, d);
        chk(d === 32'h0000_002A, "R2 select readback", d, 32'h2A);
        bus_write(8'h04, 32'h0000_0033);
        bus_read(8'h00, d);
        chk(d === 32'h0000_002A, "R2 write at other offset ignored", d, 32'h2A);
        bus_read(8'h04, d);
        chk(d === 32'h0, "R2 other offset reads zero", d, 32'h0);

        // R3: ID register
        win_write(8'h00, 32'hA5FF_FFFF);
        check_reg(8'h00, 32'hA500_0000, "R3 ID writable field");

        // R4: version register
        check_reg(8'h01, 32'h0017_0020, "R4 version value");
        win_write(8'h01, 32'hFFFF_FFFF);
        check_reg(8'h01, 32'h0017_0020, "R4 version ignores writes");

        // R6: unimplemented indices
        win_write(8'h05, 32'hFFFF_FFFF);
        check_reg(8'h05, 32'h0, "R6 index 0x05 reads zero");
        win_write(8'h40, 32'hFFFF_FFFF);
        check_reg(8'h40, 32'h0, "R6 index 0x40 reads zero");
        check_reg(8'h3E, 32'h0001_0000, "R6 write to 0x40 left entry 23 untouched");

        // R5: entry fields
        win_write(8'h16, 32'hFFFE_FF41);
        win_write(8'h17, 32'h02FF_FFFF);
        check_reg(8'h16, 32'h0000_0041, "R5 entry 3 low word");
        check_reg(8'h17, 32'h0200_0000, "R5 entry 3 high word");
        win_write(8'h1A, 32'h0000_0052);
        win_write(8'h1B, 32'h0400_0000);
        win_write(8'h3E, 32'h0000_00E7);
        win_write(8'h3F, 32'h8000_0000);
        check_reg(8'h3E, 32'h0000_00E7, "R5 entry 23 low word");
        check_reg(8'h1E, 32'h0001_0000, "R5 entry 7 still masked");

        // R7: single edge, exact timing
        @(negedge clk);
        irq_in[3] = 1'b1;
        exp_q.push_back({8'h41, 8'h02});
        @(negedge clk);
        chk(msg_valid === 1'b0, "R7 message not before second edge", {31'h0, msg_valid}, 32'h0);
        irq_in[3] = 1'b0;
        @(negedge clk);
        chk(msg_valid === 1'b1, "R7 message after second edge", {31'h0, msg_valid}, 32'h1);
        chk({msg_vector, msg_dest} === 16'h4102, "R7 message content", {16'h0, msg_vector, msg_dest}, 32'h4102);
        repeat (3) @(negedge clk);

        // R7: held-high input gives one message only
        @(negedge clk);
        irq_in[5] = 1'b1;
        exp_q.push_back({8'h52, 8'h04});
        repeat (12) @(negedge clk);
        irq_in[5] = 1'b0;
        repeat (3) @(negedge clk);

        // R9: simultaneous edges in ascending order
        pulse((24'h1 << 23) | (24'h1 << 5) | (24'h1 << 3), '{16'h4102, 16'h5204, 16'hE780});
        repeat (6) @(negedge clk);

        // R8: masked input dropped, unmasked neighbour still served
        pulse(24'h1 << 7, none);
        pulse((24'h1 << 7) | (24'h1 << 3), '{16'h4102});
        repeat (4) @(negedge clk);
        win_write(8'h1E, 32'h0000_0077);
        repeat (6) @(negedge clk);
        chk(exp_q.size() == 0, "R8 masked edge produced no late message", exp_q.size(), 32'h0);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R7/R9 all expected messages seen", exp_q.size(), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule